// File: doc/BRIEF.md
# Dual-Role SPI Byte Shift Engine

This block moves bytes between a parallel handshake and a four-wire serial link. It acts as bus master or as bus slave, picked by a static input. It uses one clock mode only: SCK rests low, each rising SCK edge launches a bit and each falling edge captures one. The most significant bit goes first. On the parallel side, a byte is offered with `tx_valid` and taken when `tx_ready` is high. Each completed byte comes back as a one-cycle `rx_valid` pulse that the receive FIFO logic uses.

As master, the engine makes SCK from the system clock by dividing it by 2, 4, 8 or 16. It starts a byte only when one is offered. If another byte is waiting when the current one ends, the clock keeps running with no gap. As slave, SCK, the master data line and the active-low select are first brought into the system clock domain through a synchronizer chain. The byte to be sent must be held before the first SCK edge of the frame. The busy flag follows line activity, and it behaves differently in each role when frames follow each other. The output enables follow the enable input, the role and, for a slave, the select line.

Top module: `spi_shift_engine`

## Requirements
- R1: As master, SCK rests low and each high phase and each low phase lasts 2^div_sel system clock cycles (div_sel 0,1,2,3 give divide ratios 2,4,8,16).
- R2: As master, the byte on `mosi_out` goes out MSB first, with each new bit appearing together with a rising SCK edge. `miso_in` is captured on falling edges, and the first bit captured lands in bit 7 of `rx_data`.
- R3: When enabled as master and idle, `tx_ready` is high. With `tx_valid` low, SCK stays low and no frame starts.
- R4: In both roles, the end of a frame gives a `rx_valid` pulse exactly one cycle wide, carrying the received byte on `rx_data`.
- R5: As master, a byte held on `tx_valid` during a frame is taken in the cycle of that frame's last falling edge. `busy` then stays high, and the next rising edge comes exactly one half period after that falling edge.
- R6: As master with nothing pending, `busy` and SCK both go low on the same clock edge that completes the last falling SCK edge, which is also the edge that raises `rx_valid`.
- R7: `miso_oe` is high only while the block is enabled, in the slave role, and `nss_in` is low. It follows these inputs without a clock delay.
- R8: `sck_oe` and `mosi_oe` are high only while the block is enabled in the master role. Dropping `enable` during a frame stops it: `busy`, SCK and `tx_ready` go low, and no `rx_valid` follows.
- R9: As slave, the held byte leaves on `miso_out` MSB first, changing after each rising `sck_in` edge. `mosi_in` is captured on falling edges, MSB first.
- R10: As slave, `busy` is high from the first rising SCK edge of a frame until the frame ends. It is low in the cycle of `rx_valid` and between frames.
- R11: As slave, `tx_ready` is high only when no byte is held and no frame is in progress. A frame with no byte held sends all zeros.
- R12: As slave, raising `nss_in` in mid-frame drops that frame: no `rx_valid` appears, and the held byte is released so `tx_ready` returns high. The next frame starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; when low, all line drivers are released |
| is_master | input | 1 | 1 selects the master role, 0 the slave role |
| div_sel | input | SEL_W | Master SCK divide select, ratio 2^(div_sel+1) |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | A transmit byte is offered |
| tx_ready | output | 1 | The engine takes the offered byte this cycle |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| busy | output | 1 | Line activity status |
| sck_out | output | 1 | Master serial clock |
| sck_oe | output | 1 | Drive enable for SCK |
| sck_in | input | 1 | Serial clock seen as slave |
| mosi_out | output | 1 | Master data out |
| mosi_oe | output | 1 | Drive enable for master data out |
| mosi_in | input | 1 | Master data seen as slave |
| miso_in | input | 1 | Slave data seen as master |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for slave data out |
| nss_in | input | 1 | Active-low slave select |

## Verification
The bench builds the engine with an 8-bit byte, a 2-bit divide select and a 2-stage synchronizer. The 2-bit select lets all four divide ratios run, including the one-cycle half period, where the frame-end load and the next rising edge fall on adjacent cycles. With two synchronizer stages, a slave SCK half period of six system cycles leaves room to see `busy` low between slave frames. It also allows a mid-frame select release to be seen after the synchronizer.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   // One serial clock event per cycle at most: launch on rise, capture on fall
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_evt_t;

endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
   parameter int                STAGES = 2,
   parameter int                WIDTH  = 1,
   parameter logic [WIDTH-1:0]  INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_eng_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_eng_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_eng_sckgen.sv
module spi_eng_sckgen #(
   parameter int SEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [SEL_W-1:0]      div_sel,
   output logic                  sck,
   output spi_eng_pkg::sck_evt_t evt
);

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("spi_eng_sckgen: SEL_W must be 1..3");
   end

   localparam int              CNT_W = (1 << SEL_W) - 1;
   localparam logic [CNT_W:0]  ONE   = {{CNT_W{1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   half_m1;
   logic             hit;

   always_comb begin
      half_m1 = (ONE << div_sel) - ONE;
      hit     = run && ({1'b0, cnt} == half_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (hit) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign evt.rise = hit & ~sck;
   assign evt.fall = hit &  sck;

   // R1: a stopped generator leaves SCK at its resting low level
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sck);

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  load,
   input  logic [DATA_W-1:0]     load_data,
   input  spi_eng_pkg::sck_evt_t evt,
   input  logic                  sample_bit,
   output logic                  out_bit,
   output logic                  at_first,
   output logic                  frame_end,
   output logic                  rx_valid,
   output logic [DATA_W-1:0]     rx_data
);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_eng_shifter: DATA_W must be at least 2");
   end

   localparam int               IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sreg;
   logic [DATA_W-2:0] rx_sh;
   logic [DATA_W-1:0] rx_next;
   logic              is_last;

   always_comb begin
      rx_next   = {rx_sh, sample_bit};
      is_last   = (idx == LAST);
      at_first  = (idx == '0);
      frame_end = evt.fall && is_last && !clear;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx      <= '0;
         sreg     <= '0;
         rx_sh    <= '0;
         out_bit  <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (load)                     sreg <= load_data;
         else if (evt.rise && !clear)  sreg <= {sreg[DATA_W-2:0], 1'b0};
         if (evt.rise && !clear)       out_bit <= sreg[DATA_W-1];
         if (clear) begin
            idx <= '0;
         end else if (evt.fall) begin
            rx_sh <= rx_next[DATA_W-2:0];
            idx   <= is_last ? '0 : idx + IDX_W'(1);
            if (is_last) begin
               rx_valid <= 1'b1;
               rx_data  <= rx_next;
            end
         end
      end
   end

   // R4: a received byte is announced for exactly one cycle
   a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R2: launch and capture never fall in the same cycle
   a_r2_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt.rise && evt.fall));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              is_master,
   input  logic [SEL_W-1:0]  div_sel,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              sck_in,
   output logic              mosi_out,
   output logic              mosi_oe,
   input  logic              mosi_in,
   input  logic              miso_in,
   output logic              miso_out,
   output logic              miso_oe,
   input  logic              nss_in
);

   import spi_eng_pkg::*;

   localparam int          LINES     = 3;
   localparam logic [2:0]  LINE_INIT = 3'b100;   // select idles high

   // synchronized slave-side lines
   logic [LINES-1:0] line_s;
   logic             sck_s, mosi_s, nss_s, sck_d;

   spi_eng_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES), .INIT(LINE_INIT)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({nss_in, mosi_in, sck_in}),
      .q     (line_s)
   );

   assign sck_s  = line_s[0];
   assign mosi_s = line_s[1];
   assign nss_s  = line_s[2];

   // control state
   logic     active;      // master frame sequence running
   logic     in_frame;    // slave frame in progress
   logic     armed;       // slave byte held for the next frame
   logic     gen_run, gen_sck;
   sck_evt_t gen_evt, evt;
   logic     slv_ok, clear, sample_bit;
   logic     at_first, frame_end, out_bit;
   logic     mst_ready, slv_ready, accept;

   assign gen_run = active && is_master && enable;

   spi_eng_sckgen #(.SEL_W(SEL_W)) u_sckgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (gen_run),
      .div_sel (div_sel),
      .sck     (gen_sck),
      .evt     (gen_evt)
   );

   always_comb begin
      slv_ok     = enable && !is_master && !nss_s;
      clear      = !enable || (!is_master && nss_s);
      sample_bit = is_master ? miso_in : mosi_s;
      if (is_master) begin
         evt = gen_evt;
      end else begin
         evt.rise = slv_ok &&  sck_s && !sck_d;
         evt.fall = slv_ok && !sck_s &&  sck_d;
      end
      mst_ready = enable &&  is_master && (!active || frame_end);
      slv_ready = enable && !is_master && !armed && !in_frame;
      tx_ready  = mst_ready || slv_ready;
      accept    = tx_valid && tx_ready;
   end

   spi_eng_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .load       (accept),
      .load_data  (tx_data),
      .evt        (evt),
      .sample_bit (sample_bit),
      .out_bit    (out_bit),
      .at_first   (at_first),
      .frame_end  (frame_end),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         active   <= 1'b0;
         in_frame <= 1'b0;
         armed    <= 1'b0;
      end else begin
         sck_d <= sck_s;

         if (!enable || !is_master) active <= 1'b0;
         else if (frame_end)        active <= tx_valid;
         else if (accept)           active <= 1'b1;

         if (clear || frame_end)         in_frame <= 1'b0;
         else if (evt.rise && at_first)  in_frame <= 1'b1;

         if (!enable || is_master)                    armed <= 1'b0;
         else if (accept)                             armed <= 1'b1;
         else if (frame_end || (in_frame && nss_s))   armed <= 1'b0;
      end
   end

   assign busy     = is_master ? active : in_frame;
   assign sck_out  = gen_sck;
   assign sck_oe   = enable && is_master;
   assign mosi_oe  = enable && is_master;
   assign mosi_out = out_bit;
   assign miso_out = out_bit;
   assign miso_oe  = enable && !is_master && !nss_in;

   // R10: a slave frame end always leaves busy low for that cycle
   a_r10_slave_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && rx_valid) |-> !busy);

   // R8: a disabled block reports no activity one cycle later
   a_r8_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);

   // R6: a master byte completes on a falling SCK edge
   a_r6_end_low: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && rx_valid) |-> !sck_out);

endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;

   localparam int SH = 6;   // slave SCK half period in system cycles

   logic       clk = 1'b0;
   logic       rst_n, enable, is_master;
   logic [1:0] div_sel;
   logic [7:0] tx_data;
   logic       tx_valid, tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid, busy;
   logic       sck_out, sck_oe, sck_in;
   logic       mosi_out, mosi_oe, mosi_in;
   logic       miso_in, miso_out, miso_oe, nss_in;

   int total = 0;
   int bad   = 0;
   int rx_cnt = 0;
   logic [7:0]  rx_last = 8'h00;
   logic [15:0] mshift  = 16'h0000;

   always #10 clk = ~clk;

   spi_shift_engine #(.DATA_W(8), .SEL_W(2), .SYNC_STAGES(2)) u_spi_shift_engine (
      .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
      .div_sel(div_sel), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .busy(busy), .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in),
      .mosi_out(mosi_out), .mosi_oe(mosi_oe), .mosi_in(mosi_in),
      .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
      .nss_in(nss_in)
   );

   // receive monitor
   always @(posedge clk) begin
      if (rst_n && rx_valid) begin
         rx_cnt  = rx_cnt + 1;
         rx_last = rx_data;
      end
   end

   // remote slave model for the master role: new bit on each rising SCK
   always @(posedge sck_out) begin
      miso_in = mshift[15];
      mshift  = {mshift[14:0], 1'b0};
   end

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      check(!busy && !rx_valid && !sck_out, "R3 reset idle", {busy, rx_valid, sck_out}, 0);
      check(!tx_ready && !sck_oe && !miso_oe, "R8 reset disabled", {tx_ready, sck_oe, miso_oe}, 0);
   endtask

   task automatic t_idle_no_data();
      int c0;
      enable = 1'b1; is_master = 1'b1; div_sel = 2'd0;
      c0 = rx_cnt;
      repeat (30) @(negedge clk);
      check(tx_ready, "R3 ready when idle", tx_ready, 1);
      check(!sck_out && !busy && rx_cnt == c0, "R3 no frame without data",
            {sck_out, busy}, 0);
      check(sck_oe && mosi_oe && !miso_oe, "R8 master drives", {sck_oe, mosi_oe, miso_oe}, 6);
   endtask

   task automatic master_xfer(input logic [1:0] sel, input int n,
                              input logic [7:0] t0, input logic [7:0] t1,
                              input logic [7:0] m0, input logic [7:0] m1);
      int h, qi, rxn, hi, lo, perr, nb, guard;
      bit acc, seen, prev, drop;
      logic [15:0] mcap, mexp;
      h = 1 << sel; qi = 0; rxn = 0; hi = 0; lo = 0; perr = 0; nb = 0; guard = 0;
      seen = 0; prev = 0; drop = 0; mcap = '0;
      div_sel = sel; is_master = 1'b1; enable = 1'b1;
      mshift = {m0, m1};
      @(negedge clk);
      tx_data = t0; tx_valid = 1'b1;
      acc = tx_ready;
      while (rxn < n && guard < 3000) begin
         @(negedge clk);
         guard++;
         if (acc) begin
            qi++;
            if (qi < n) tx_data = t1;
            else        tx_valid = 1'b0;
         end
         if (!prev && sck_out) begin
            if (seen && lo != h) perr++;
            seen = 1; hi = 0;
         end
         if (prev && !sck_out) begin
            if (hi != h) perr++;
            lo = 0; nb++;
            mcap = {mcap[14:0], mosi_out};
         end
         if (sck_out) hi++; else lo++;
         if (seen && !busy && !rx_valid) drop = 1;
         if (rx_valid) begin
            check(rx_data == ((rxn == 0) ? m0 : m1), "R2 R4 master receive byte", rx_data,
                  (rxn == 0) ? m0 : m1);
            check(busy == (rxn < n - 1), "R5 R6 busy at byte end", busy, rxn < n - 1);
            check(!sck_out, "R6 sck low at end", sck_out, 0);
            rxn++;
         end
         acc = tx_valid && tx_ready;
         prev = sck_out;
      end
      mexp = (n == 1) ? {8'h00, t0} : {t0, t1};
      check(perr == 0, "R1 half period length", perr, 0);
      check(mcap == mexp && nb == 8 * n, "R2 mosi bit order", mcap, mexp);
      if (n > 1) check(!drop, "R5 busy held across frames", drop, 0);
      @(negedge clk);
      check(!rx_valid, "R4 pulse width one cycle", rx_valid, 0);
      repeat (3 * h + 4) @(negedge clk);
      check(!sck_out && !busy, "R6 idle after last byte", {sck_out, busy}, 0);
   endtask

   task automatic t_master_disable();
      int c0;
      is_master = 1'b1; enable = 1'b1; div_sel = 2'd3;
      @(negedge clk);
      tx_data = 8'h5A; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(busy, "R8 frame running before disable", busy, 1);
      c0 = rx_cnt;
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy && !sck_out && !tx_ready, "R8 disable stops frame",
            {busy, sck_out, tx_ready}, 0);
      check(!sck_oe && !mosi_oe, "R8 drivers released", {sck_oe, mosi_oe}, 0);
      enable = 1'b1;
      repeat (40) @(negedge clk);
      check(rx_cnt == c0 && !sck_out, "R8 no byte after abort", rx_cnt - c0, 0);
   endtask

   task automatic t_oe();
      is_master = 1'b1; enable = 1'b1; nss_in = 1'b0;
      @(negedge clk);
      check(!miso_oe, "R7 master never drives miso", miso_oe, 0);
      is_master = 1'b0;
      @(negedge clk);
      check(miso_oe && !sck_oe && !mosi_oe, "R7 R8 slave selected", {miso_oe, sck_oe, mosi_oe}, 4);
      enable = 1'b0;
      #1;
      check(!miso_oe, "R7 disabled slave released", miso_oe, 0);
      enable = 1'b1; nss_in = 1'b1;
      #1;
      check(!miso_oe, "R7 deselected slave released", miso_oe, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic slave_load(input logic [7:0] b);
      bit ok;
      int g;
      g = 0;
      tx_data = b; tx_valid = 1'b1;
      do begin
         ok = tx_ready;
         @(negedge clk);
         g++;
      end while (!ok && g < 50);
      tx_valid = 1'b0;
   endtask

   task automatic slave_bits(input logic [7:0] m, input int nb, output logic [7:0] got,
                             output logic b1, output logic r1);
      got = '0; b1 = 1'b0; r1 = 1'b0;
      for (int i = 0; i < nb; i++) begin
         sck_in = 1'b1; mosi_in = m[7 - i];
         repeat (SH) @(negedge clk);
         got = {got[6:0], miso_out};
         if (i == 0) begin b1 = busy; r1 = tx_ready; end
         sck_in = 1'b0;
         repeat (SH) @(negedge clk);
      end
   endtask

   task automatic t_slave_pair();
      logic [7:0] g;
      logic b1, r1;
      int c0;
      is_master = 1'b0; enable = 1'b1; nss_in = 1'b1; sck_in = 1'b0;
      repeat (4) @(negedge clk);
      check(tx_ready, "R11 slave ready when empty", tx_ready, 1);
      slave_load(8'hC3);
      check(!tx_ready, "R11 not ready while holding", tx_ready, 0);
      nss_in = 1'b0;
      repeat (4) @(negedge clk);
      c0 = rx_cnt;
      slave_bits(8'h2D, 8, g, b1, r1);
      check(g == 8'hC3, "R9 slave sends held byte", g, 8'hC3);
      check(rx_cnt == c0 + 1 && rx_last == 8'h2D, "R4 R9 slave receive byte", rx_last, 8'h2D);
      check(b1, "R10 busy in first frame", b1, 1);
      check(!busy, "R10 busy low between frames", busy, 0);
      slave_load(8'h81);
      slave_bits(8'hE4, 8, g, b1, r1);
      check(g == 8'h81, "R9 second slave byte", g, 8'h81);
      check(rx_last == 8'hE4 && rx_cnt == c0 + 2, "R4 second slave receive", rx_last, 8'hE4);
      check(b1 && !r1, "R10 R11 busy and not ready mid-frame", {b1, r1}, 2);
      nss_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_slave_empty();
      logic [7:0] g;
      logic b1, r1;
      nss_in = 1'b0;
      repeat (4) @(negedge clk);
      slave_bits(8'h3C, 8, g, b1, r1);
      check(g == 8'h00, "R11 empty frame sends zeros", g, 0);
      check(rx_last == 8'h3C, "R4 empty frame still receives", rx_last, 8'h3C);
      nss_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_slave_abort();
      logic [7:0] g;
      logic b1, r1;
      int c0;
      slave_load(8'hA5);
      nss_in = 1'b0;
      repeat (4) @(negedge clk);
      c0 = rx_cnt;
      slave_bits(8'hF0, 3, g, b1, r1);
      nss_in = 1'b1;
      repeat (8) @(negedge clk);
      check(rx_cnt == c0 && !busy, "R12 aborted frame discarded", rx_cnt - c0, 0);
      check(tx_ready, "R12 held byte released", tx_ready, 1);
      slave_load(8'h69);
      nss_in = 1'b0;
      repeat (4) @(negedge clk);
      slave_bits(8'h96, 8, g, b1, r1);
      check(g == 8'h69, "R12 next frame starts at bit 7 (send)", g, 8'h69);
      check(rx_last == 8'h96 && rx_cnt == c0 + 1, "R12 next frame starts at bit 7 (receive)",
            rx_last, 8'h96);
      nss_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; enable = 1'b0; is_master = 1'b1; div_sel = 2'd0;
      tx_data = '0; tx_valid = 1'b0; sck_in = 1'b0; mosi_in = 1'b0;
      miso_in = 1'b0; nss_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_no_data();
      master_xfer(2'd0, 1, 8'hB4, 8'h00, 8'h1E, 8'h00);
      master_xfer(2'd1, 1, 8'h01, 8'h00, 8'h80, 8'h00);
      master_xfer(2'd2, 1, 8'h96, 8'h00, 8'h6A, 8'h00);
      master_xfer(2'd3, 1, 8'hFF, 8'h00, 8'h55, 8'h00);
      master_xfer(2'd0, 2, 8'hA1, 8'h5C, 8'h3B, 8'hC4);
      master_xfer(2'd2, 2, 8'h0F, 8'hF0, 8'h99, 8'h42);
      t_master_disable();
      t_oe();
      t_slave_pair();
      t_slave_empty();
      t_slave_abort();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1..R12 run hung actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule